// File: doc/BRIEF.md
# Flash Status and Write-Protection Guard

This block keeps the status byte of a serial NOR flash with a 1 MiB array (20-bit byte address). It also decides whether each program or erase request may start. It receives one-cycle strobes from an instruction decoder: set latch, clear latch, load status, page program, auto-increment program, sector erase, block erase and chip erase. It also receives a completion pulse from the array sequencer and the level of the write-protect pin. It answers every program or erase request with a registered grant or deny pulse. A granted request raises the busy bit until the sequencer reports completion.

A request is granted only when four conditions hold: the write-enable latch is set, the device is idle, no control strobe arrives in the same cycle, and the target region lies wholly below the protected window. A three-bit protect code selects that window, which always sits at the top of the array. A lock-down bit freezes the protect code and itself, but only while the write-protect pin is held low. At most one strobe is expected per cycle.

Top module: `flash_sr_guard`

## Requirements
- R1: After a synchronous reset, status_o reads 8'h1C and grant_o and deny_o are 0. The status layout is bit0 busy, bit1 write-enable latch, bits 4:2 protect code (bit2 is the code's lsb), bit5 constant 0, bit6 auto-increment mode, bit7 lock-down.
- R2: While idle, the set-latch strobe sets status bit1 on the next cycle. The clear-latch strobe clears bit1 and bit6.
- R3: A program or erase request made while the latch is 0 yields deny_o on the next cycle and leaves the status unchanged.
- R4: While busy, every request is denied and the latch is kept. This includes a request in the same cycle as the completion pulse. The set-latch, clear-latch and load-status strobes are ignored while busy.
- R5: A single-address request is denied when the address is at or above the protected base. Code 0 protects nothing, and codes 1..4 protect from F0000h, E0000h, C0000h and 80000h upward. Codes 5..7 protect the whole array.
- R6: A sector erase (4 KiB) or block erase (64 KiB) is judged on the last address of the aligned region that holds req_addr_i. It is denied if that region reaches into the protected window.
- R7: A chip erase is granted only when the protect code is 0.
- R8: The load-status strobe with the latch set copies data bits 4:2 into the protect code and data bit7 into the lock-down bit, then clears the latch. With the latch at 0 it has no effect.
- R9: While wp_pin_i is low and lock-down is 1, a load-status strobe changes neither the protect code nor lock-down, but it still clears the latch.
- R10: While wp_pin_i is high, lock-down has no effect and a load-status strobe updates the protect code and lock-down.
- R11: A granted request sets busy on the same edge as grant_o. The completion pulse clears busy and, after a page program or erase, the latch. A completion pulse while idle changes nothing.
- R12: A granted auto-increment request sets bit6. Its completion keeps the latch unless the programmed address was the highest unprotected address. In that case the latch and bit6 are both cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin_i | input | 1 | Write-protect pin level, low enables lock-down |
| wren_i | input | 1 | Set write-enable latch strobe |
| wrdi_i | input | 1 | Clear latch and leave auto-increment mode |
| wrsr_i | input | 1 | Load status strobe |
| wrsr_data_i | input | 8 | Status value to load |
| page_prog_i | input | 1 | Page program request |
| aai_prog_i | input | 1 | Auto-increment program request |
| sect_erase_i | input | 1 | Sector erase request |
| blk_erase_i | input | 1 | Block erase request |
| chip_erase_i | input | 1 | Chip erase request |
| req_addr_i | input | 20 | Request address |
| op_done_i | input | 1 | Completion pulse from array sequencer |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request accepted, one cycle after it |
| deny_o | output | 1 | Request refused, one cycle after it |

## Verification
The completion pulse and a new request can arrive in the same cycle. The bench provokes this by raising both strobes together while a page program is busy. A correct design judges the request against the pre-edge state, so it must deny it. On the same edge, busy and the latch must drop, giving status 8'h00 together with deny_o. The other collision is a load-status strobe during a pin-low lock. It is judged by the protect code holding while the latch still clears.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  typedef enum logic [2:0] {
    K_PAGE = 3'd0,
    K_AAI  = 3'd1,
    K_SECT = 3'd2,
    K_BLK  = 3'd3,
    K_CHIP = 3'd4
  } req_kind_e;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_BP_LO = 2;
  localparam int ST_AAI  = 6;
  localparam int ST_LOCK = 7;

endpackage

// File: rtl/flash_prot_decode.sv
module flash_prot_decode
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16
) (
  input  logic [2:0]        bp_i,
  input  req_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] hi_unprot_o
);

  localparam logic [ADDR_W-1:0] ONES      = '1;
  localparam logic [ADDR_W-1:0] SECT_MASK = {{(ADDR_W-SECT_W){1'b0}}, {SECT_W{1'b1}}};
  localparam logic [ADDR_W-1:0] BLK_MASK  = {{(ADDR_W-BLK_W){1'b0}}, {BLK_W{1'b1}}};
  localparam int SHIFT0 = ADDR_W - 5;

  logic              prot_on;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] end_addr;

  // Window base: top 1/16 .. 1/2 for codes 1..4, whole array above that.
  always_comb begin
    prot_on = (bp_i != 3'd0);
    if (bp_i >= 3'd1 && bp_i <= 3'd4)
      base = ONES << (SHIFT0 + int'(bp_i));
    else if (bp_i == 3'd0)
      base = ONES;
    else
      base = '0;
  end

  // The region's last address decides overlap, as the window sits at the top.
  always_comb begin
    case (kind_i)
      K_PAGE, K_AAI: end_addr = addr_i;
      K_SECT:        end_addr = addr_i | SECT_MASK;
      K_BLK:         end_addr = addr_i | BLK_MASK;
      default:       end_addr = ONES;
    endcase
  end

  assign hit_o       = prot_on && (end_addr >= base);
  assign hi_unprot_o = prot_on ? (base - 1'b1) : ONES;

endmodule

// File: rtl/flash_sr_state.sv
module flash_sr_state
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [2:0]        new_bp_i,
  input  logic              new_lock_i,
  input  logic              accept_i,
  input  req_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              op_done_i,
  input  logic [ADDR_W-1:0] hi_unprot_i,
  output logic              busy_o,
  output logic              wel_o,
  output logic              aai_o,
  output logic [2:0]        bp_o,
  output logic              lock_o
);

  req_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              locked;

  assign locked = !wp_pin_i && lock_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      wel_o  <= 1'b0;
      aai_o  <= 1'b0;
      bp_o   <= 3'b111;
      lock_o <= 1'b0;
      kind_q <= K_PAGE;
      addr_q <= '0;
    end else if (busy_o) begin
      if (op_done_i) begin
        busy_o <= 1'b0;
        if (kind_q != K_AAI || addr_q == hi_unprot_i) begin
          wel_o <= 1'b0;
          aai_o <= 1'b0;
        end
      end
    end else if (wrdi_i) begin
      wel_o <= 1'b0;
      aai_o <= 1'b0;
    end else if (wren_i) begin
      wel_o <= 1'b1;
    end else if (wrsr_i) begin
      if (wel_o) begin
        wel_o <= 1'b0;
        if (!locked) begin
          bp_o   <= new_bp_i;
          lock_o <= new_lock_i;
        end
      end
    end else if (accept_i) begin
      busy_o <= 1'b1;
      kind_q <= kind_i;
      addr_q <= addr_i;
      if (kind_i == K_AAI) aai_o <= 1'b1;
    end
  end

  // R9: a pin-low lock freezes the protect code and the lock bit
  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (rst)
    (!wp_pin_i && lock_o) |=> ($stable(bp_o) && lock_o));

  // R2: the latch rises only after a set-latch strobe
  a_r2_wel_source: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_o) |-> $past(wren_i));

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              page_prog_i,
  input  logic              aai_prog_i,
  input  logic              sect_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              op_done_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o
);

  logic              req_any, ctrl_any, hit, accept;
  req_kind_e         kind;
  logic [ADDR_W-1:0] hi_unprot;
  logic              busy, wel, aai, lock;
  logic [2:0]        bp;
  logic              unused_wrsr_bits;

  assign unused_wrsr_bits = ^{wrsr_data_i[6:5], wrsr_data_i[1:0]};
  assign req_any  = page_prog_i | aai_prog_i | sect_erase_i | blk_erase_i | chip_erase_i;
  assign ctrl_any = wren_i | wrdi_i | wrsr_i;

  always_comb begin
    if (chip_erase_i)      kind = K_CHIP;
    else if (blk_erase_i)  kind = K_BLK;
    else if (sect_erase_i) kind = K_SECT;
    else if (aai_prog_i)   kind = K_AAI;
    else                   kind = K_PAGE;
  end

  flash_prot_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_decode (
    .bp_i        (bp),
    .kind_i      (kind),
    .addr_i      (req_addr_i),
    .hit_o       (hit),
    .hi_unprot_o (hi_unprot)
  );

  assign accept = req_any && !ctrl_any && wel && !busy && !hit;

  flash_sr_state #(.ADDR_W(ADDR_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .wp_pin_i    (wp_pin_i),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .wrsr_i      (wrsr_i),
    .new_bp_i    (wrsr_data_i[4:2]),
    .new_lock_i  (wrsr_data_i[7]),
    .accept_i    (accept),
    .kind_i      (kind),
    .addr_i      (req_addr_i),
    .op_done_i   (op_done_i),
    .hi_unprot_i (hi_unprot),
    .busy_o      (busy),
    .wel_o       (wel),
    .aai_o       (aai),
    .bp_o        (bp),
    .lock_o      (lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= accept;
      deny_o  <= req_any && !accept;
    end
  end

  always_comb begin
    status_o = 8'h00;
    status_o[ST_BUSY] = busy;
    status_o[ST_WEL]  = wel;
    status_o[ST_BP_LO +: 3] = bp;
    status_o[ST_AAI]  = aai;
    status_o[ST_LOCK] = lock;
  end

  // R3: no latch, no grant
  a_r3_no_latch_deny: assert property (@(posedge clk) disable iff (rst)
    (req_any && !wel) |=> (deny_o && !grant_o));

  // R4: requests while busy are refused
  a_r4_busy_deny: assert property (@(posedge clk) disable iff (rst)
    (req_any && busy) |=> (deny_o && !grant_o));

  // R7: chip erase needs an empty protect code
  a_r7_chip_needs_zero: assert property (@(posedge clk) disable iff (rst)
    (chip_erase_i && bp != 3'd0) |=> deny_o);

  // R11: a grant is always seen with busy set
  a_r11_grant_busy: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> busy);

endmodule

// File: tb/test_flash_sr_guard.sv
`timescale 1ns/1ps
module test_flash_sr_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wp_pin = 1'b1;
  logic [8:0]  strb = '0;
  logic [7:0]  wdata = '0;
  logic [19:0] addr = '0;
  logic [7:0]  status;
  logic        grant, deny;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam logic [8:0] S_WREN = 9'h001, S_WRDI = 9'h002, S_WRSR = 9'h004,
                         S_PAGE = 9'h008, S_AAI  = 9'h010, S_SECT = 9'h020,
                         S_BLK  = 9'h040, S_CHIP = 9'h080, S_DONE = 9'h100;

  always #4 clk = ~clk;

  flash_sr_guard i_flash_sr_guard (
    .clk(clk), .rst(rst), .wp_pin_i(wp_pin),
    .wren_i(strb[0]), .wrdi_i(strb[1]), .wrsr_i(strb[2]), .wrsr_data_i(wdata),
    .page_prog_i(strb[3]), .aai_prog_i(strb[4]), .sect_erase_i(strb[5]),
    .blk_erase_i(strb[6]), .chip_erase_i(strb[7]), .req_addr_i(addr),
    .op_done_i(strb[8]), .status_o(status), .grant_o(grant), .deny_o(deny)
  );

  // {expect grant, kind (0 page,1 sector,2 block,3 chip), protect code, address}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 2'd0, 3'd0, 20'hFFFFF}, {1'b1, 2'd0, 3'd1, 20'hEFFFF},
    {1'b0, 2'd0, 3'd1, 20'hF0000}, {1'b1, 2'd0, 3'd2, 20'hDFFFF},
    {1'b0, 2'd0, 3'd2, 20'hE0000}, {1'b1, 2'd0, 3'd3, 20'hBFFFF},
    {1'b0, 2'd0, 3'd3, 20'hC0000}, {1'b1, 2'd0, 3'd4, 20'h7FFFF},
    {1'b0, 2'd0, 3'd4, 20'h80000}, {1'b0, 2'd0, 3'd5, 20'h00000},
    {1'b0, 2'd0, 3'd7, 20'h12345}, {1'b1, 2'd1, 3'd3, 20'hBF123},
    {1'b0, 2'd1, 3'd1, 20'hF0800}, {1'b1, 2'd2, 3'd1, 20'hE4000},
    {1'b0, 2'd2, 3'd4, 20'h80000}, {1'b1, 2'd3, 3'd0, 20'h00000},
    {1'b0, 2'd3, 3'd1, 20'h00000}, {1'b0, 2'd3, 3'd6, 20'h00000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] s, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    strb = s; addr = a; wdata = d;
    @(negedge clk);
    strb = '0;
  endtask

  task automatic set_bp(input logic [2:0] bp);
    step(S_WREN, '0, '0);
    step(S_WRSR, '0, {3'b000, bp, 2'b00});
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status, 8'h1C);
    chk("R1 reset grant", grant, 0);
    chk("R1 reset deny", deny, 0);

    // Vector walk: protection windows, erase regions, chip erase
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      logic [8:0]  s;
      string       tag;
      v = VEC[i];
      set_bp(v[22:20]);
      step(S_WREN, '0, '0);
      case (v[24:23])
        2'd0: begin s = S_PAGE; tag = "R5 window"; end
        2'd1: begin s = S_SECT; tag = "R6 sector"; end
        2'd2: begin s = S_BLK;  tag = "R6 block"; end
        default: begin s = S_CHIP; tag = "R7 chip"; end
      endcase
      step(s, v[19:0], '0);
      chk(tag, {grant, deny}, {v[25], ~v[25]});
      if (v[25]) begin
        step(S_DONE, '0, '0);
        chk("R11 done clears busy and latch", status[1:0], 2'b00);
      end
    end

    // R3: no latch
    step(S_WRDI, '0, '0);
    set_bp(3'd0);
    chk("R8 load status", status, 8'h00);
    step(S_PAGE, 20'h00000, '0);
    chk("R3 deny without latch", {grant, deny}, 2'b01);
    chk("R3 status unchanged", status, 8'h00);

    // R2
    step(S_WREN, '0, '0);
    chk("R2 set latch", status, 8'h02);
    step(S_WRDI, '0, '0);
    chk("R2 clear latch", status, 8'h00);

    // R8: load without latch ignored
    step(S_WRSR, '0, 8'h0C);
    chk("R8 load ignored without latch", status, 8'h00);

    // R4 / R11: busy handling and the done-plus-request collision
    step(S_WREN, '0, '0);
    step(S_PAGE, 20'h00100, '0);
    chk("R11 grant", {grant, deny}, 2'b10);
    chk("R11 busy set", status, 8'h03);
    step(S_WRDI, '0, '0);
    chk("R4 clear latch ignored while busy", status, 8'h03);
    step(S_SECT, 20'h00000, '0);
    chk("R4 busy deny", {grant, deny}, 2'b01);
    chk("R4 latch kept", status, 8'h03);
    step(S_DONE | S_PAGE, 20'h00200, '0);
    chk("R4 same-cycle request denied", {grant, deny}, 2'b01);
    chk("R11 done same cycle", status, 8'h00);
    step(S_DONE, '0, '0);
    chk("R11 idle done ignored", status, 8'h00);

    // R12: auto-increment programming
    set_bp(3'd1);
    step(S_WREN, '0, '0);
    step(S_AAI, 20'hEFFFE, '0);
    chk("R12 aai grant", {grant, status}, {1'b1, 8'h47});
    step(S_DONE, '0, '0);
    chk("R12 latch kept", status, 8'h46);
    step(S_AAI, 20'hEFFFF, '0);
    chk("R12 aai top grant", {grant, status}, {1'b1, 8'h47});
    step(S_DONE, '0, '0);
    chk("R12 top address ends mode", status, 8'h04);
    step(S_WREN, '0, '0);
    step(S_AAI, 20'hEFFF0, '0);
    step(S_DONE, '0, '0);
    chk("R12 mid aai", status, 8'h46);
    step(S_WRDI, '0, '0);
    chk("R2 clear latch leaves aai", status, 8'h04);

    // R9 / R10: lock-down with the pin
    step(S_WREN, '0, '0);
    step(S_WRSR, '0, 8'h88);
    chk("R8 lock loaded", status, 8'h88);
    @(negedge clk) wp_pin = 1'b0;
    step(S_WREN, '0, '0);
    chk("R9 latch set while locked", status, 8'h8A);
    step(S_WRSR, '0, 8'h00);
    chk("R9 locked load blocked", status, 8'h88);
    step(S_WREN, '0, '0);
    step(S_WRSR, '0, 8'h1C);
    chk("R9 locked load blocked again", status, 8'h88);
    @(negedge clk) wp_pin = 1'b1;
    step(S_WREN, '0, '0);
    step(S_WRSR, '0, 8'h00);
    chk("R10 pin high unlocks", status, 8'h00);

    report();
  end

endmodule